// File: doc/BRIEF.md
# Horizontal Microprogram Command Sequencer

This block is the control path of a scan test engine. A host raises a start strobe with a command opcode. The opcode picks a fixed-size slice of an internal microprogram ROM. A microprogram counter then walks through wide (horizontal) microwords, one per cycle. Each microword holds three fields, from most significant to least significant: a jump target, a micro-operation, and a bank of control bits. The control bits go straight out as data path strobes and as the test clock and mode-select pin levels.

The micro-operations are continue, jump, branch when a data path condition is true, and branch when it is false. The conditions come from the data path as flags: counter at zero and counter at one. The first two rows of every slice are one shared prologue. The prologue loads the count, then tests it for zero. The control path is Moore style. The outputs are a function of registered state only, so they change only at a rising clock edge. When the sequencer reaches the end row it raises done for that cycle. It then returns to idle, unless a new command is accepted in the same cycle.

Top module: `uSeqTop`

## Requirements
- R1: After reset busy and done are 0 and ctrl is all zero. ctrl stays all zero in every cycle in which busy is 0.
- R2: A start (startValid high while busy is 0 or done is 1) with opcode 0, 1 or 2 is accepted. In the next cycle busy is 1 and ctrl is 0x040, the shared count-load row with only bit 6 (count load) set. In the cycle after that ctrl is 0, the shared zero-test row.
- R3: startValid is ignored while busy is 1 and done is 0. The running command's pin trace and its done cycle do not change.
- R4: ctrl bits are: 0 TCK level, 1 TMS level, 2 serializer shift, 3 serializer load, 4 count mux, 5 count decrement, 6 count load, 7 to 9 further data path loads. cond[0] means the count is zero and cond[1] means the count is one. Opcode 0 (clock burst) with a loaded count N gives N+1 single-cycle TCK-high pulses and N decrements. TMS is 0 throughout, and done rises in busy cycle 2N+4.
- R5: Opcode 1 (mode-high burst) has the same timing and pulse count as opcode 0. TMS equals the TCK level in every cycle.
- R6: Opcode 2 (scan shift) with N of 1 or more gives N TCK pulses, with a serializer shift in exactly those cycles, and N-1 decrements. TMS is high only on the last pulse, and done rises in busy cycle 3N+2. With N=0 there are no pulses and done rises in busy cycle 4.
- R7: Opcodes 3 to 7 are illegal. The sequencer goes straight to the end row: busy and done are high for one cycle and ctrl stays zero, so TCK never toggles.
- R8: done is high for exactly one cycle, with TCK low. After done, busy drops in the next cycle if no start was accepted.
- R9: A start presented in the done cycle is accepted without an idle cycle. busy stays high and the next cycle shows the new command's first row (0x040 when the command is legal).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start strobe for a new command |
| opcode | input | 3 | Command opcode, latched on acceptance |
| cond | input | 2 | Data path flags: [0] count is zero, [1] count is one |
| ctrl | output | 10 | Horizontal control bits of the current microword |
| busy | output | 1 | A command is running |
| done | output | 1 | End row reached this cycle |

## Verification
The two functions that can meet in one cycle are the completion of one command and the acceptance of the next. The bench provokes this by raising startValid in the cycle where done is observed high. It does this for legal-to-legal, legal-to-illegal and illegal-to-legal pairs. It judges the result by busy staying high and by the next cycle showing the new command's first row, and then by tracing the new command to its own done cycle. A start strobe raised in the middle of a run, away from done, is the opposite case: it must leave the pulse counts and the done cycle of the running command unchanged.

// File: rtl/uSeqPkg.sv
package uSeqPkg;
  localparam int OPC_W    = 3;
  localparam int LOW_W    = 3;
  localparam int COND_N   = 2;
  localparam int NUM_CMDS = 3;
  localparam int MOP_W    = $clog2(2 + 2 * COND_N);

  localparam logic [LOW_W-1:0] END_LOW = '1;

  localparam logic [MOP_W-1:0] MOP_CONT  = MOP_W'(0);
  localparam logic [MOP_W-1:0] MOP_JUMP  = MOP_W'(1);
  localparam logic [MOP_W-1:0] MOP_BIF0  = MOP_W'(2);
  localparam logic [MOP_W-1:0] MOP_BIFN0 = MOP_W'(3);
  localparam logic [MOP_W-1:0] MOP_BIF1  = MOP_W'(4);

  typedef struct packed {
    logic iwordLoad;
    logic iwordDec;
    logic bitsLoad;
    logic cntLoad;
    logic cntDec;
    logic cntMux;
    logic serLoad;
    logic serShift;
    logic tms;
    logic tck;
  } ctrlBits_t;

  localparam int CTRL_W = $bits(ctrlBits_t);

  typedef struct packed {
    logic [LOW_W-1:0] jmp;
    logic [MOP_W-1:0] mop;
    ctrlBits_t        ctrl;
  } uword_t;

  typedef struct packed {
    logic accept;
    logic illegal;
    logic advance;
  } seqStrobes_t;

  // Microprogram contents, computed per address (rows 0 and 1 shared).
  function automatic uword_t ucodeWord(input logic [OPC_W-1:0] op,
                                       input logic [LOW_W-1:0] low);
    uword_t w;
    w = '0;
    if (low == LOW_W'(0)) begin
      w.mop = MOP_CONT;
      w.ctrl.cntLoad = 1'b1;
    end else if (low == LOW_W'(1)) begin
      w.mop = MOP_BIFN0;
      w.jmp = LOW_W'(3);
    end else if (low != END_LOW) begin
      case (op)
        OPC_W'(0), OPC_W'(1): begin
          if (low == LOW_W'(2)) begin
            w.mop = MOP_JUMP; w.jmp = END_LOW;
            w.ctrl.tck = 1'b1; w.ctrl.tms = op[0];
          end else if (low == LOW_W'(3)) begin
            w.mop = MOP_JUMP; w.jmp = LOW_W'(1);
            w.ctrl.tck = 1'b1; w.ctrl.tms = op[0]; w.ctrl.cntDec = 1'b1;
          end
        end
        OPC_W'(2): begin
          if (low == LOW_W'(2)) begin
            w.mop = MOP_JUMP; w.jmp = END_LOW;
          end else if (low == LOW_W'(3)) begin
            w.mop = MOP_BIF1; w.jmp = LOW_W'(5);
          end else if (low == LOW_W'(4)) begin
            w.mop = MOP_JUMP; w.jmp = LOW_W'(1);
            w.ctrl.serShift = 1'b1; w.ctrl.tck = 1'b1; w.ctrl.cntDec = 1'b1;
          end else if (low == LOW_W'(5)) begin
            w.mop = MOP_JUMP; w.jmp = END_LOW;
            w.ctrl.serShift = 1'b1; w.ctrl.tck = 1'b1; w.ctrl.tms = 1'b1;
          end
        end
        default: ;
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/uSeqCtrl.sv
module uSeqCtrl
  import uSeqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [OPC_W-1:0] opcode,
  input  logic             atEnd,
  output seqStrobes_t      strb,
  output logic             busy,
  output logic             done
);
  logic running;

  always_comb begin
    done         = running && atEnd;
    strb.accept  = startValid && (!running || atEnd);
    strb.illegal = int'(opcode) >= NUM_CMDS;
    strb.advance = running && !atEnd;
    busy         = running;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            running <= 1'b0;
    else if (strb.accept) running <= 1'b1;
    else if (done)        running <= 1'b0;
  end
endmodule

// File: rtl/uSeqPath.sv
module uSeqPath
  import uSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [COND_N-1:0] cond,
  output logic              atEnd,
  output ctrlBits_t         ctrlBits
);
  logic [OPC_W-1:0] opReg;
  logic [LOW_W-1:0] upc;
  logic [LOW_W-1:0] nextLow;
  uword_t           word;
  logic             taken;
  logic             isBranch;

  always_comb begin
    word     = ucodeWord(opReg, upc);
    ctrlBits = word.ctrl;
    atEnd    = (upc == END_LOW);
  end

  // Condition select: even codes branch on true, odd codes on false.
  always_comb begin
    taken = 1'b0;
    for (int k = 0; k < COND_N; k++) begin
      if (word.mop == MOP_W'(2 + 2 * k)) taken = cond[k];
      if (word.mop == MOP_W'(3 + 2 * k)) taken = ~cond[k];
    end
    isBranch = (word.mop >= MOP_BIF0);
    if ((word.mop == MOP_JUMP) || (isBranch && taken)) nextLow = word.jmp;
    else                                               nextLow = upc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg <= '0;
      upc   <= END_LOW;
    end else if (strb.accept) begin
      opReg <= opcode;
      upc   <= strb.illegal ? END_LOW : '0;
    end else if (strb.advance) begin
      upc <= nextLow;
    end
  end
endmodule

// File: rtl/uSeqTop.sv
module uSeqTop
  import uSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [COND_N-1:0] cond,
  output logic [CTRL_W-1:0] ctrl,
  output logic              busy,
  output logic              done
);
  seqStrobes_t strb;
  ctrlBits_t   ctrlBits;
  logic        atEnd;

  uSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opcode(opcode),
    .atEnd(atEnd), .strb(strb), .busy(busy), .done(done)
  );

  uSeqPath uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .opcode(opcode), .cond(cond),
    .atEnd(atEnd), .ctrlBits(ctrlBits)
  );

  assign ctrl = busy ? ctrlBits : '0;
endmodule

// File: rtl/uSeqChecker.sv
module uSeqChecker
  import uSeqPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic [OPC_W-1:0]  opcode,
  input logic [CTRL_W-1:0] ctrl,
  input logic              busy,
  input logic              done
);
  localparam logic [CTRL_W-1:0] FIRST_ROW = CTRL_W'(10'h040);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ctrl == '0));

  assert_first_row_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && (!busy || done) && (int'(opcode) < NUM_CMDS))
      |=> (busy && ctrl == FIRST_ROW));

  assert_hold_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && startValid) |=> busy);

  assert_illegal_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && (!busy || done) && (int'(opcode) >= NUM_CMDS))
      |=> (done && ctrl == '0));

  assert_done_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startValid) |=> !busy);

  assert_done_tck_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && !ctrl[0]));

  assert_chain_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && startValid) |=> busy);
endmodule

bind uSeqTop uSeqChecker uChk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .opcode(opcode),
  .ctrl(ctrl), .busy(busy), .done(done)
);

// File: tb/sim_uSeqTop.sv
module sim_uSeqTop;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startValid = 1'b0;
  logic [2:0] opcode = '0;
  logic [1:0] cond;
  logic [9:0] ctrl;
  logic       busy, done;
  int         cnt = 0;
  int         loadVal = 0;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  uSeqTop u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opcode(opcode),
    .cond(cond), .ctrl(ctrl), .busy(busy), .done(done)
  );

  // Data path model: counter driven by the load/decrement strobes.
  always @(posedge clk) begin
    if (ctrl[6])      cnt <= loadVal;
    else if (ctrl[5]) cnt <= cnt - 1;
  end
  assign cond = {cnt == 1, cnt == 0};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic startCmd(input int op, input int n);
    startValid = 1'b1;
    opcode = 3'(op);
    loadVal = n;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  // Called at the sample point of busy cycle 1.
  task automatic traceCmd(input int op, input int n, input int pokeAt,
                          input bit chain, input int chainOp, input int chainN);
    int tckN = 0, tmsN = 0, shN = 0, decN = 0, mism = 0, doneCyc = 0;
    int lastTck = 0, tmsCyc = 0;
    int expDone, expTck, expTms, expSh, expDec;
    string req;
    bit legal = (op < 3);
    req = (op == 0) ? "R4" : (op == 1) ? "R5" : (op == 2) ? "R6" : "R7";
    for (int cyc = 1; cyc <= 200; cyc++) begin
      if (!busy) break;
      if (cyc == 1 && legal) check(ctrl == 10'h040, "R2", "first row", ctrl, 10'h040);
      if (cyc == 2 && legal) check(ctrl == 10'h000, "R2", "second row", ctrl, 0);
      if (ctrl[0]) begin tckN++; lastTck = cyc; end
      if (ctrl[1]) begin tmsN++; tmsCyc = cyc; end
      if (ctrl[2]) shN++;
      if (ctrl[5]) decN++;
      if (op == 1 && ctrl[1] != ctrl[0]) mism++;
      if (op == 2 && ((ctrl[1] && !ctrl[0]) || (ctrl[2] != ctrl[0]))) mism++;
      if (!legal && ctrl != 0) mism++;
      if (done) begin
        doneCyc = cyc;
        check(!ctrl[0], "R8", "TCK low at done", ctrl[0], 0);
        if (chain) begin
          startValid = 1'b1; opcode = 3'(chainOp); loadVal = chainN;
        end
        break;
      end
      if (cyc == pokeAt) begin startValid = 1'b1; opcode = 3'd2; end
      @(negedge clk);
      startValid = 1'b0;
    end
    if (!legal) begin
      expDone = 1; expTck = 0; expTms = 0; expSh = 0; expDec = 0;
    end else if (op < 2) begin
      expDone = 2 * n + 4; expTck = n + 1; expSh = 0; expDec = n;
      expTms = (op == 1) ? n + 1 : 0;
    end else begin
      expDone = (n == 0) ? 4 : 3 * n + 2; expTck = n; expSh = n;
      expDec = (n == 0) ? 0 : n - 1; expTms = (n == 0) ? 0 : 1;
    end
    check(doneCyc == expDone, req, "done cycle", doneCyc, expDone);
    check(tckN == expTck, req, "TCK pulses", tckN, expTck);
    check(tmsN == expTms, req, "TMS high cycles", tmsN, expTms);
    check(shN == expSh, req, "shift strobes", shN, expSh);
    check(decN == expDec, req, "decrements", decN, expDec);
    check(mism == 0, req, "pin relation", mism, 0);
    if (op == 2 && n > 0) check(tmsCyc == lastTck, "R6", "TMS on last pulse", tmsCyc, lastTck);
    if (pokeAt > 0) check(doneCyc == expDone, "R3", "mid-run start ignored", doneCyc, expDone);
  endtask

  task automatic expectIdle();
    @(negedge clk);
    check(!busy && !done, "R8", "idle after done", busy, 0);
    check(ctrl == 0, "R1", "ctrl zero when idle", ctrl, 0);
  endtask

  task automatic chainCheck(input int op);
    @(negedge clk);
    startValid = 1'b0;
    check(busy == 1'b1, "R9", "busy kept across chain", busy, 1);
    if (op < 3) check(ctrl == 10'h040, "R9", "chained first row", ctrl, 10'h040);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1", "reset busy/done", {busy, done}, 0);
    check(ctrl == 0, "R1", "reset ctrl", ctrl, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(ctrl == 0 && !busy, "R1", "idle ctrl", ctrl, 0);

    for (int op = 0; op < 3; op++) begin
      for (int n = 0; n <= 6; n++) begin
        startCmd(op, n);
        traceCmd(op, n, 0, 1'b0, 0, 0);
        expectIdle();
      end
    end
    for (int op = 3; op < 8; op++) begin
      startCmd(op, 4);
      traceCmd(op, 4, 0, 1'b0, 0, 0);
      expectIdle();
    end

    // R3: start strobes in mid-run are ignored
    startCmd(0, 3);
    traceCmd(0, 3, 3, 1'b0, 0, 0);
    expectIdle();
    startCmd(2, 3);
    traceCmd(2, 3, 5, 1'b0, 0, 0);
    expectIdle();

    // R9: completion and new acceptance in the same cycle
    startCmd(0, 2);
    traceCmd(0, 2, 0, 1'b1, 2, 3);
    chainCheck(2);
    traceCmd(2, 3, 0, 1'b1, 5, 0);
    chainCheck(5);
    traceCmd(5, 0, 0, 1'b1, 1, 1);
    chainCheck(1);
    traceCmd(1, 1, 0, 1'b0, 0, 0);
    expectIdle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule